// File: doc/BRIEF.md
# Two-Pin Register-Mapped GPIO Expander

This block is a small peripheral that sits behind a serial transport front end. The front end turns SPI or I2C traffic into single-cycle byte writes and reads on a simple host port. The register file behind that port holds six bytes:

- a control byte with the interrupt enables;
- a temperature byte;
- one configuration byte per pin;
- one data byte per pin.

The temperature value and the per-pin ADC results come from outside as byte inputs. The serial transport, the converter and the sensor are not part of this block.

Each pin is configured on its own. It can be an analog input, which captures the supplied ADC byte when the converter strobes completion. It can be a digital input, which mirrors the synchronised pin level as an all-zeros or all-ones byte. It can be a push-pull output driven from bit 0 of its data byte. It can be a PWM output whose duty cycle is the data byte. The meaning of the data byte therefore changes with the pin mode.

A pin in either input mode can flag an interrupt on a rising edge, a falling edge or both. The converter can flag one on completion. The interrupt line is a level. It is gated by a global enable and stays high until the host reads the control byte.

Top module: `gpio_xpndr`

## Requirements
- R1: The map is: address 0 control, 1 temperature, 2 and 3 pin configuration for pin 1 and pin 2, 4 and 5 pin data for pin 1 and pin 2. Control keeps only bit 7 (global enable), bit 2 (ADC enable), bit 1 (pin-2 enable) and bit 0 (pin-1 enable). A configuration byte keeps only bits [4:0]. Unused bits read 0, and addresses 6 and 7 read 0x00.
- R2: The temperature byte reads the `temp_in` value sampled one cycle earlier. Host writes to it have no effect.
- R3: Pin mode is configuration bits [1:0]: 00 analog in, 01 digital in, 10 push-pull out, 11 PWM out. The output enable is high exactly in the two output modes. The pull-up request equals configuration bit 2 in the input modes and is 0 in the output modes.
- R4: In digital input mode the data byte becomes 0xFF when the pin is high and 0x00 when it is low. The pin passes through a two-flop synchroniser, so the data byte reflects a change at most four clock edges later.
- R5: In analog input mode the data byte loads that pin's ADC byte on a cycle where `adc_done` is high, and holds otherwise.
- R6: Host writes to a data byte take effect only in the two output modes. In input modes they are ignored.
- R7: In push-pull mode the pin output equals bit 0 of the data byte.
- R8: In PWM mode the pin output is high while a free-running 8-bit counter is below the data byte. This gives exactly `duty` high cycles in every 256, and a duty of 0x00 holds the output low.
- R9: Interrupt mode is configuration bits [4:3]: 00 none, 01 rising, 10 falling, 11 both. A pin event is flagged only if its enable bit is set, its mode is an input and a matching edge is seen on the synchronised level.
- R10: When the ADC enable bit is set, a cycle with `adc_done` high flags an ADC event.
- R11: Flagged events stay pending until a host read of address 0. An event in the same cycle as that read stays pending. `irq` is high exactly when bit 7 of control is 1 and some event is pending.
- R12: After reset every register reads 0x00, and `irq`, `pin_out`, `pin_oe` and `pin_pu` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe from the transport front end |
| host_rd | input | 1 | Read strobe (a read of address 0 clears pending events) |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | DATA_W | Write byte |
| host_rdata | output | DATA_W | Read byte for the current address |
| temp_in | input | DATA_W | Temperature value from the sensor |
| adc_done | input | 1 | Conversion complete strobe |
| adc_data | input | NUM_PINS*DATA_W | ADC results, pin 1 in the low byte |
| pin_in | input | NUM_PINS | Pad input levels |
| pin_out | output | NUM_PINS | Pad output levels |
| pin_oe | output | NUM_PINS | Pad output enables |
| pin_pu | output | NUM_PINS | Pad pull-up requests |
| irq | output | 1 | Level interrupt request |

## Verification
Random bursts of writes to all eight addresses with random bytes are followed by random reads. Both are compared with a bench model of the field masks and of the mode-dependent write rules. This separates a wrong mask or a wrong address decode from a wrong ignore rule.

Directed pin sequences then raise and lower each pin under every interrupt mode. Each edge type is shown to fire only in its own mode. The same edges are repeated with the pin enable cleared, with the pin in an output mode, and with the global enable cleared, and the last case also shows that pending events survive until the control read. PWM duty values of 0x00, 0x01, 0x80 and 0xFF are measured by counting high cycles over a full period, which exposes off-by-one errors in the compare.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

   typedef enum logic [1:0] {
      PM_ANALOG   = 2'b00,
      PM_DIGITAL  = 2'b01,
      PM_PUSHPULL = 2'b10,
      PM_PWM      = 2'b11
   } pin_mode_e;

   typedef enum logic [1:0] {
      IM_NONE = 2'b00,
      IM_RISE = 2'b01,
      IM_FALL = 2'b10,
      IM_BOTH = 2'b11
   } irq_mode_e;

   // Field order sets bit positions: [4:3] irq mode, [2] pull-up, [1:0] pin mode
   typedef struct packed {
      irq_mode_e imode;
      logic      pull;
      pin_mode_e pmode;
   } pin_cfg_t;

   localparam int unsigned CFG_W     = $bits(pin_cfg_t);
   localparam int unsigned ADR_CTRL  = 0;
   localparam int unsigned ADR_TEMP  = 1;
   localparam int unsigned ADR_PCFG0 = 2;

endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpx_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpx_pin.sv
module gpx_pin
   import gpx_pkg::*;
#(
   parameter int unsigned DW          = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  pin_cfg_t      cfg,
   input  logic          host_we,
   input  logic [DW-1:0] wdata,
   input  logic          adc_strobe,
   input  logic [DW-1:0] adc_byte,
   input  logic [DW-1:0] pwm_cnt,
   input  logic          pad_in,
   output logic [DW-1:0] data,
   output logic          edge_evt,
   output logic          pad_out,
   output logic          pad_oe,
   output logic          pad_pu
);

   logic lvl, lvl_q, rise, fall, hit, is_input;

   gpx_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pad_in),
      .q    (lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign rise     = lvl & ~lvl_q;
   assign fall     = ~lvl & lvl_q;
   assign is_input = ~cfg.pmode[1];

   always_comb begin
      unique case (cfg.imode)
         IM_RISE: hit = rise;
         IM_FALL: hit = fall;
         IM_BOTH: hit = rise | fall;
         default: hit = 1'b0;
      endcase
   end

   assign edge_evt = is_input & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data <= '0;
      end else begin
         unique case (cfg.pmode)
            PM_ANALOG:  if (adc_strobe) data <= adc_byte;
            PM_DIGITAL: data <= {DW{lvl}};
            default:    if (host_we) data <= wdata;
         endcase
      end
   end

   always_comb begin
      unique case (cfg.pmode)
         PM_PUSHPULL: pad_out = data[0];
         PM_PWM:      pad_out = (pwm_cnt < data);
         default:     pad_out = 1'b0;
      endcase
   end

   assign pad_oe = cfg.pmode[1];
   assign pad_pu = is_input & cfg.pull;

   // R5 / R6: analog input ignores host writes and holds between strobes
   a_r6_analog_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.pmode == PM_ANALOG && !adc_strobe) |=> $stable(data));

   // R4: digital input leaves only all-zeros or all-ones in the data byte
   a_r4_digital_levels: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.pmode == PM_DIGITAL) |=> (data == '0 || data == '1));

   // R8: zero duty never drives high
   a_r8_pwm_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.pmode == PM_PWM && data == '0) |-> !pad_out);

endmodule

// File: rtl/gpio_xpndr.sv
module gpio_xpndr
   import gpx_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned NUM_PINS    = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       host_wr,
   input  logic                       host_rd,
   input  logic [ADDR_W-1:0]          host_addr,
   input  logic [DATA_W-1:0]          host_wdata,
   output logic [DATA_W-1:0]          host_rdata,
   input  logic [DATA_W-1:0]          temp_in,
   input  logic                       adc_done,
   input  logic [NUM_PINS*DATA_W-1:0] adc_data,
   input  logic [NUM_PINS-1:0]        pin_in,
   output logic [NUM_PINS-1:0]        pin_out,
   output logic [NUM_PINS-1:0]        pin_oe,
   output logic [NUM_PINS-1:0]        pin_pu,
   output logic                       irq
);

   localparam int unsigned PDAT0   = ADR_PCFG0 + NUM_PINS;
   localparam int unsigned NSRC    = NUM_PINS + 1;
   localparam int unsigned GEN_BIT = DATA_W - 1;
   localparam logic [DATA_W-1:0] CTRL_MASK =
      DATA_W'((1 << GEN_BIT) | ((1 << NSRC) - 1));

   generate
      if (NUM_PINS != 2) begin : g_bad_pins
         $error("register map is laid out for two pins");
      end
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be at least 8");
      end
      if ((1 << ADDR_W) < PDAT0 + NUM_PINS) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   logic [DATA_W-1:0] ctrl_q, temp_q, cnt_q;
   logic [NSRC-1:0]   pend_q, evt;
   logic [NUM_PINS-1:0] pin_evt;
   pin_cfg_t          pcfg_q [NUM_PINS];
   logic [DATA_W-1:0] pin_data [NUM_PINS];
   logic              ctrl_rd;

   assign ctrl_rd = host_rd && (host_addr == ADDR_W'(ADR_CTRL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         temp_q <= '0;
         cnt_q  <= '0;
         pend_q <= '0;
      end else begin
         temp_q <= temp_in;
         cnt_q  <= cnt_q + 1'b1;
         if (host_wr && host_addr == ADDR_W'(ADR_CTRL))
            ctrl_q <= host_wdata & CTRL_MASK;
         pend_q <= (ctrl_rd ? '0 : pend_q) | evt;
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pcfg_q[gi] <= '0;
            else if (host_wr && host_addr == ADDR_W'(ADR_PCFG0 + gi))
               pcfg_q[gi] <= pin_cfg_t'(host_wdata[CFG_W-1:0]);
         end

         gpx_pin #(.DW(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg       (pcfg_q[gi]),
            .host_we   (host_wr && host_addr == ADDR_W'(PDAT0 + gi)),
            .wdata     (host_wdata),
            .adc_strobe(adc_done),
            .adc_byte  (adc_data[gi*DATA_W +: DATA_W]),
            .pwm_cnt   (cnt_q),
            .pad_in    (pin_in[gi]),
            .data      (pin_data[gi]),
            .edge_evt  (pin_evt[gi]),
            .pad_out   (pin_out[gi]),
            .pad_oe    (pin_oe[gi]),
            .pad_pu    (pin_pu[gi])
         );

         assign evt[gi] = pin_evt[gi] & ctrl_q[gi];

         // R9: a pin event only arises while the pin is in an input mode
         a_r9_evt_input_only: assert property (@(posedge clk) disable iff (!rst_n)
            pin_evt[gi] |-> !pcfg_q[gi].pmode[1]);
      end
   endgenerate

   assign evt[NUM_PINS] = adc_done & ctrl_q[NUM_PINS];
   assign irq = ctrl_q[GEN_BIT] & (|pend_q);

   always_comb begin
      host_rdata = '0;
      if (host_addr == ADDR_W'(ADR_CTRL)) host_rdata = ctrl_q;
      if (host_addr == ADDR_W'(ADR_TEMP)) host_rdata = temp_q;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (host_addr == ADDR_W'(ADR_PCFG0 + i)) host_rdata = DATA_W'(pcfg_q[i]);
         if (host_addr == ADDR_W'(PDAT0 + i))     host_rdata = pin_data[i];
      end
   end

   // R11: a control read with no new event drops the interrupt next cycle
   a_r11_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_rd && !(|evt)) |=> !irq);

   // R2: the temperature byte follows its input, never host data
   a_r2_temp_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == ADDR_W'(ADR_TEMP)) |=> (temp_q == $past(temp_in)));

endmodule

// File: tb/test_gpio_xpndr.sv
module test_gpio_xpndr;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0, host_rd = 1'b0;
   logic [2:0] host_addr = '0;
   logic [7:0] host_wdata = '0, host_rdata;
   logic [7:0] temp_in = '0;
   logic       adc_done = 1'b0;
   logic [15:0] adc_data = '0;
   logic [1:0] pin_in = '0, pin_out, pin_oe, pin_pu;
   logic       irq;

   int checks = 0, errors = 0;
   logic [7:0] m_ctrl;
   logic [7:0] m_cfg [2];
   logic [7:0] m_data [2];

   always #2 clk = ~clk;

   gpio_xpndr i_gpio_xpndr (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .temp_in(temp_in), .adc_done(adc_done), .adc_data(adc_data),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
      .irq(irq)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(2);
   endtask

   task automatic adc_pulse();
      @(negedge clk);
      adc_done = 1'b1;
      @(negedge clk);
      adc_done = 1'b0;
   endtask

   // Expected read value from the requirement-level model
   function automatic logic [7:0] model_rd(input int a);
      case (a)
         0: return m_ctrl;
         1: return temp_in;
         2: return m_cfg[0];
         3: return m_cfg[1];
         4: return m_data[0];
         5: return m_data[1];
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic is_out(input logic [7:0] cfg);
      return cfg[1];
   endfunction

   task automatic pwm_count(input logic [7:0] duty);
      int hi = 0;
      wr(3'd4, duty);
      for (int k = 0; k < 256; k++) begin
         @(negedge clk);
         if (pin_out[0]) hi++;
      end
      chk("R8 pwm high count", 8'(hi), duty);
      checks++;
      if (hi > 255 && duty != 8'hFF) begin
         errors++;
         $display("FAIL R8 count overflow got %0d exp %0d", hi, duty);
      end
   endtask

   task automatic edge_on(input int p, input logic v);
      @(negedge clk);
      pin_in[p] = v;
      idle(4);
   endtask

   logic [7:0] r;

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5EED_0042));
      do_reset();

      // R12: reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), r);
         chk("R12 reset read", r, 8'h00);
      end
      chk("R12 irq", {7'd0, irq}, 8'h00);
      chk("R12 pads", {2'b00, pin_out, pin_oe, pin_pu}, 8'h00);

      // R1 / R2 / R6: random register traffic against the model
      m_ctrl = '0; m_cfg[0] = '0; m_cfg[1] = '0; m_data[0] = '0; m_data[1] = '0;
      for (int n = 0; n < 200; n++) begin
         int a, b;
         logic [7:0] d;
         a = $urandom_range(0, 7);
         d = 8'($urandom);
         temp_in = 8'($urandom);
         wr(3'(a), d);
         case (a)
            0: m_ctrl = d & 8'h87;
            2, 3: begin
               m_cfg[a-2] = d & 8'h1F;
               if (m_cfg[a-2][1:0] == 2'b01) m_data[a-2] = 8'h00;
            end
            4, 5: if (is_out(m_cfg[a-4])) m_data[a-4] = d;
            default: ;
         endcase
         idle(3);
         b = $urandom_range(0, 7);
         rd(3'(b), r);
         chk("R1 R2 R6 random read", r, model_rd(b));
         chk("R11 irq quiet", {7'd0, irq}, 8'h00);
      end

      do_reset();
      temp_in = 8'h00;

      // R1: masks and unmapped addresses
      wr(3'd0, 8'hFF); rd(3'd0, r); chk("R1 control mask", r, 8'h87);
      wr(3'd2, 8'hFF); rd(3'd2, r); chk("R1 config mask", r, 8'h1F);
      wr(3'd2, 8'h00); wr(3'd0, 8'h00);
      rd(3'd6, r); chk("R1 addr 6", r, 8'h00);
      rd(3'd7, r); chk("R1 addr 7", r, 8'h00);

      // R2: temperature write ignored
      temp_in = 8'h5A; idle(2);
      wr(3'd1, 8'h33); rd(3'd1, r); chk("R2 temperature", r, 8'h5A);

      // R3 / R7: push-pull and pad controls
      wr(3'd2, 8'h02); wr(3'd4, 8'h01); idle(1);
      chk("R7 pushpull bit0 high", {7'd0, pin_out[0]}, 8'h01);
      chk("R3 oe in output", {7'd0, pin_oe[0]}, 8'h01);
      wr(3'd4, 8'hFE); idle(1);
      chk("R7 pushpull bit0 low", {7'd0, pin_out[0]}, 8'h00);
      wr(3'd2, 8'h06); idle(1);
      chk("R3 no pull-up in output", {7'd0, pin_pu[0]}, 8'h00);
      wr(3'd2, 8'h05); idle(1);
      chk("R3 pull-up in input", {7'd0, pin_pu[0]}, 8'h01);
      chk("R3 oe off in input", {7'd0, pin_oe[0]}, 8'h00);

      // R4 / R6: digital input mirror
      edge_on(0, 1'b1); rd(3'd4, r); chk("R4 digital high", r, 8'hFF);
      edge_on(0, 1'b0); rd(3'd4, r); chk("R4 digital low", r, 8'h00);
      wr(3'd4, 8'h55); rd(3'd4, r); chk("R6 write ignored digital", r, 8'h00);

      // R5 / R6: analog capture
      wr(3'd3, 8'h00);
      adc_data = {8'hC3, 8'h11};
      idle(2);
      rd(3'd5, r); chk("R5 no capture without strobe", r, 8'h00);
      adc_pulse();
      rd(3'd5, r); chk("R5 analog capture", r, 8'hC3);
      rd(3'd4, r); chk("R5 digital pin untouched", r, 8'h00);
      wr(3'd5, 8'h77); rd(3'd5, r); chk("R6 write ignored analog", r, 8'hC3);

      // R8: PWM duty
      wr(3'd2, 8'h03);
      pwm_count(8'h00);
      pwm_count(8'h01);
      pwm_count(8'h80);
      pwm_count(8'hFF);

      // R9 / R11: rising mode on pin 1
      wr(3'd2, 8'h09); wr(3'd0, 8'h81);
      edge_on(0, 1'b1); chk("R9 rising fires", {7'd0, irq}, 8'h01);
      rd(3'd0, r); chk("R11 control readback", r, 8'h81);
      chk("R11 cleared by read", {7'd0, irq}, 8'h00);
      edge_on(0, 1'b0); chk("R9 rising ignores fall", {7'd0, irq}, 8'h00);

      // falling mode
      wr(3'd2, 8'h11);
      edge_on(0, 1'b1); chk("R9 falling ignores rise", {7'd0, irq}, 8'h00);
      edge_on(0, 1'b0); chk("R9 falling fires", {7'd0, irq}, 8'h01);
      rd(3'd0, r);

      // none mode
      wr(3'd2, 8'h01);
      edge_on(0, 1'b1); edge_on(0, 1'b0);
      chk("R9 none mode", {7'd0, irq}, 8'h00);

      // both edges on pin 2
      wr(3'd3, 8'h19); wr(3'd0, 8'h82);
      edge_on(1, 1'b1); chk("R9 both rise", {7'd0, irq}, 8'h01);
      rd(3'd0, r);
      edge_on(1, 1'b0); chk("R9 both fall", {7'd0, irq}, 8'h01);
      rd(3'd0, r);

      // pin enable cleared
      wr(3'd0, 8'h80);
      edge_on(1, 1'b1); edge_on(1, 1'b0);
      chk("R9 pin enable off", {7'd0, irq}, 8'h00);

      // output mode blocks events
      wr(3'd3, 8'h1A); wr(3'd0, 8'h82);
      edge_on(1, 1'b1); edge_on(1, 1'b0);
      chk("R9 output mode", {7'd0, irq}, 8'h00);

      // R11: global enable gates a held pending event
      wr(3'd3, 8'h19); wr(3'd0, 8'h02);
      edge_on(1, 1'b1); chk("R11 global off", {7'd0, irq}, 8'h00);
      wr(3'd0, 8'h82); chk("R11 pending kept", {7'd0, irq}, 8'h01);
      rd(3'd0, r); chk("R11 cleared again", {7'd0, irq}, 8'h00);

      // R10: converter event
      wr(3'd3, 8'h00); wr(3'd0, 8'h84);
      adc_pulse(); chk("R10 adc fires", {7'd0, irq}, 8'h01);
      rd(3'd0, r); chk("R10 cleared", {7'd0, irq}, 8'h00);
      wr(3'd0, 8'h80);
      adc_pulse(); chk("R10 adc enable off", {7'd0, irq}, 8'h00);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule